// File: doc/BRIEF.md
# Multichannel DMA Command-Port Register File

This block is the programming front end of a sixteen-channel bus DMA controller. Software talks to it through two byte-wide ports. A byte written to the command port names an operation in its upper nibble and a channel in its lower nibble. The bytes of that operation then pass through the data port, one per access, steered by an internal byte pointer. Each channel keeps an I/O port address, a 24-bit memory address, a 16-bit count (the length minus one, in units of the transfer width), a mode byte and a mask bit.

A transfer engine sits beside the block. It selects a channel on `xfer_ch`, sees that channel's I/O port and mode, and pulses `xfer_stb` once for each unit it moves. An armed channel whose mode has the start bit set then counts down and steps its address forward. When the count wraps past zero, the block raises that channel's terminal-count flag. The usual software order is: mask, set mode, set address, set count, unmask.

Top module: `dma_cmdport`

## Requirements
- R1: After reset all sixteen channels are masked (`armed` = 0), `tc` = 0, every channel register is zero, and `dat_rdata` reads 0.
- R2: Command 0x2 with channel n loads channel n's 24-bit address through three data writes: bits 7:0 first, then bits 15:8, then bits 23:16. Command 0x3 returns the same three bytes in that order on `dat_rdata`, and each `dat_re` pulse advances to the next byte.
- R3: Command 0x4 loads the 16-bit count with two data writes, low byte first. Command 0x5 reads the remaining count back in the same order.
- R4: Command 0x0 loads the 16-bit I/O port address with two data writes, low byte first. `eng_ioport` shows the value held by the channel selected on `xfer_ch`.
- R5: Command 0x7 stores one data byte as the mode, and `eng_mode` shows the mode of the channel on `xfer_ch`. The mode bits are: bit 2 start, bit 3 read (1) or write (0), bit 0 I/O-register target, bit 6 16-bit units.
- R6: Command 0x9 masks the named channel and command 0xA unmasks it. Only command 0xA sets a bit of `armed`, and only a command write changes `armed`.
- R7: Every command write resets the byte pointer. Data accesses past the last byte of the current operation are ignored and read as 0.
- R8: Undefined operation codes (for example 0x6) change no channel state. Data writes that follow them are ignored, and `dat_rdata` stays 0 except during operations 0x3 and 0x5.
- R9: A `xfer_stb` on an armed channel whose mode has the start bit set lowers its count by 1 and adds 1 to its address, or 2 when mode bit 6 is set, wrapping at 24 bits. If the channel is masked or its start bit is clear, nothing changes.
- R10: A strobe that finds a count of 0 wraps it to 0xFFFF and sets that channel's bit of `tc`. Any data write to the channel's count clears the bit. `tc` never rises without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command port write strobe |
| cmd_wdata | input | 8 | Command byte: operation in bits 7:4, channel in bits 3:0 |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data port write byte |
| dat_re | input | 1 | Data port read strobe; advances the byte pointer |
| dat_rdata | output | 8 | Byte at the pointer for operations 0x3 and 0x5, else 0 |
| xfer_stb | input | 1 | One unit transferred on channel `xfer_ch` |
| xfer_ch | input | 4 | Channel the transfer engine is working on |
| eng_ioport | output | 16 | I/O port address of channel `xfer_ch` |
| eng_mode | output | 8 | Mode byte of channel `xfer_ch` |
| armed | output | 16 | One bit per channel, set when the channel is unmasked |
| tc | output | 16 | Terminal-count flag for each channel |

## Verification
The hardest state to reach is a count wrapping from zero on a live channel. It needs the whole mask, mode, address, count and unmask sequence first, and then exactly length-many strobes. The stimulus programs a count of 2 and checks `tc` after the second strobe and again after the third. It then rewrites the count through a command that is abandoned after one byte and restarted, which shows both that the pointer resets and that the flag clears. The stimulus also covers a 16-bit channel whose address sits at the top of the 24-bit range, and two channels that must ignore strobes (one still masked, one with the start bit clear).

// File: rtl/dma_cmdport.sv
module dma_cmdport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_wdata,
  input  logic        dat_we,
  input  logic [7:0]  dat_wdata,
  input  logic        dat_re,
  output logic [7:0]  dat_rdata,
  input  logic        xfer_stb,
  input  logic [3:0]  xfer_ch,
  output logic [15:0] eng_ioport,
  output logic [7:0]  eng_mode,
  output logic [15:0] armed,
  output logic [15:0] tc
);
  localparam int NCH = 16;

  localparam logic [3:0] OP_IO   = 4'h0;
  localparam logic [3:0] OP_ADDR = 4'h2;
  localparam logic [3:0] OP_RADR = 4'h3;
  localparam logic [3:0] OP_CNT  = 4'h4;
  localparam logic [3:0] OP_RCNT = 4'h5;
  localparam logic [3:0] OP_MODE = 4'h7;
  localparam logic [3:0] OP_MASK = 4'h9;
  localparam logic [3:0] OP_ARM  = 4'hA;

  logic [15:0] io_q   [NCH];
  logic [23:0] addr_q [NCH];
  logic [15:0] cnt_q  [NCH];
  logic [7:0]  mode_q [NCH];
  logic [15:0] mask_q;
  logic [15:0] tc_q;

  logic [3:0] op_q;
  logic [3:0] ch_q;
  logic [1:0] ptr_q;
  logic [1:0] oplen;
  logic       is_rd, in_rng, wr_ok, rd_ok, stb_ok;
  logic [4:0] bsel;

  always_comb begin
    case (op_q)
      OP_IO, OP_CNT, OP_RCNT: oplen = 2'd2;
      OP_ADDR, OP_RADR:       oplen = 2'd3;
      OP_MODE:                oplen = 2'd1;
      default:                oplen = 2'd0;
    endcase
  end

  assign is_rd  = (op_q == OP_RADR) || (op_q == OP_RCNT);
  assign in_rng = ptr_q < oplen;
  assign wr_ok  = dat_we && !cmd_we && !is_rd && in_rng;
  assign rd_ok  = dat_re && !cmd_we && is_rd && in_rng;
  assign bsel   = {ptr_q, 3'b000};

  always_comb begin
    dat_rdata = 8'h00;
    if (in_rng) begin
      if (op_q == OP_RADR)      dat_rdata = addr_q[ch_q][bsel +: 8];
      else if (op_q == OP_RCNT) dat_rdata = cnt_q[ch_q][bsel[3:0] +: 8];
    end
  end

  assign stb_ok = xfer_stb && !mask_q[xfer_ch] && mode_q[xfer_ch][2]
                  && !(wr_ok && ch_q == xfer_ch);

  assign eng_ioport = io_q[xfer_ch];
  assign eng_mode   = mode_q[xfer_ch];
  assign armed      = ~mask_q;
  assign tc         = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= 4'hF;
      ch_q   <= 4'h0;
      ptr_q  <= 2'd0;
      mask_q <= '1;
      tc_q   <= '0;
      for (int i = 0; i < NCH; i++) begin
        io_q[i]   <= '0;
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        mode_q[i] <= '0;
      end
    end else begin
      if (cmd_we) begin
        op_q  <= cmd_wdata[7:4];
        ch_q  <= cmd_wdata[3:0];
        ptr_q <= 2'd0;
        if (cmd_wdata[7:4] == OP_MASK) mask_q[cmd_wdata[3:0]] <= 1'b1;
        if (cmd_wdata[7:4] == OP_ARM)  mask_q[cmd_wdata[3:0]] <= 1'b0;
      end else if (wr_ok || rd_ok) begin
        ptr_q <= ptr_q + 2'd1;
      end

      if (stb_ok) begin
        cnt_q[xfer_ch]  <= cnt_q[xfer_ch] - 16'd1;
        addr_q[xfer_ch] <= addr_q[xfer_ch] + (mode_q[xfer_ch][6] ? 24'd2 : 24'd1);
        if (cnt_q[xfer_ch] == 16'd0) tc_q[xfer_ch] <= 1'b1;
      end

      if (wr_ok) begin
        case (op_q)
          OP_IO:   io_q[ch_q][bsel[3:0] +: 8] <= dat_wdata;
          OP_ADDR: addr_q[ch_q][bsel +: 8]    <= dat_wdata;
          OP_CNT: begin
            cnt_q[ch_q][bsel[3:0] +: 8] <= dat_wdata;
            tc_q[ch_q] <= 1'b0;
          end
          OP_MODE: mode_q[ch_q] <= dat_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_cmdport_chk.sv
module dma_cmdport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [7:0]  cmd_wdata,
  input logic        xfer_stb,
  input logic [7:0]  dat_rdata,
  input logic [15:0] armed,
  input logic [15:0] tc
);
  // R6
  mask_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[7:4] == 4'h9 |=> !armed[$past(cmd_wdata[3:0])]);

  // R6
  unmask_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[7:4] == 4'hA |=> armed[$past(cmd_wdata[3:0])]);

  // R6
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(armed));

  // R8
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[7:4] != 4'h3 && cmd_wdata[7:4] != 4'h5 |=> dat_rdata == 8'h00);

  // R10
  tc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_stb |=> (tc & ~$past(tc)) == 16'h0000);
endmodule

bind dma_cmdport dma_cmdport_chk u_chk (.*);

// File: tb/tb_dma_cmdport.sv
module tb_dma_cmdport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        dat_we = 1'b0;
  logic [7:0]  dat_wdata = 8'h00;
  logic        dat_re = 1'b0;
  logic [7:0]  dat_rdata;
  logic        xfer_stb = 1'b0;
  logic [3:0]  xfer_ch = 4'h0;
  logic [15:0] eng_ioport;
  logic [7:0]  eng_mode;
  logic [15:0] armed;
  logic [15:0] tc;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  dma_cmdport dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_we = 1'b1; cmd_wdata = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    dat_we = 1'b1; dat_wdata = b;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    dat_re = 1'b1;
    @(negedge clk);
    dat_re = 1'b0;
  endtask

  task automatic stb(input logic [3:0] ch);
    xfer_stb = 1'b1; xfer_ch = ch;
    @(negedge clk);
    xfer_stb = 1'b0;
  endtask

  always begin
    @(negedge clk);
    #3;
    if (dat_re) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL monitor actual=%0h expected=none", dat_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dat_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", t, dat_rdata, e);
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(armed, 16'h0000, "R1 armed");
    chk(tc, 16'h0000, "R1 tc");
    chk(dat_rdata, 8'h00, "R1 rdata");
    cmd(8'h35);
    rd(8'h00, "R1 addr zero");

    // channel 5: 8-bit, start, address 0x123456, count 2
    cmd(8'h95); cmd(8'h75); wr(8'h04);
    cmd(8'h25); wr(8'h56); wr(8'h34); wr(8'h12);
    cmd(8'h45); wr(8'h02); wr(8'h00);
    cmd(8'hA5);
    chk(armed, 16'h0020, "R6 unmask ch5");
    cmd(8'h35);
    rd(8'h56, "R2 addr b0"); rd(8'h34, "R2 addr b1"); rd(8'h12, "R2 addr b2");
    rd(8'h00, "R7 read past end");
    cmd(8'h55);
    rd(8'h02, "R3 cnt lo"); rd(8'h00, "R3 cnt hi");

    // R9/R10 countdown to wrap
    stb(4'h5); stb(4'h5);
    chk(tc, 16'h0000, "R10 no tc before wrap");
    stb(4'h5);
    chk(tc, 16'h0020, "R10 tc on wrap");
    cmd(8'h35);
    rd(8'h59, "R9 addr +3"); rd(8'h34, "R9 addr b1"); rd(8'h12, "R9 addr b2");
    cmd(8'h55);
    rd(8'hFF, "R10 cnt wrapped lo"); rd(8'hFF, "R10 cnt wrapped hi");

    // R7 restart count write; R10 clear
    cmd(8'h45); wr(8'h07);
    chk(tc, 16'h0000, "R10 tc cleared by count write");
    cmd(8'h45); wr(8'h09); wr(8'h00);
    cmd(8'h55);
    rd(8'h09, "R7 pointer reset lo"); rd(8'h00, "R7 pointer reset hi");

    // channel 10: 16-bit units, address at top of range
    cmd(8'h9A); cmd(8'h7A); wr(8'h44);
    cmd(8'h2A); wr(8'hFE); wr(8'hFF); wr(8'hFF);
    cmd(8'h4A); wr(8'h10); wr(8'h00);
    cmd(8'hAA);
    stb(4'hA);
    cmd(8'h3A);
    rd(8'h00, "R9 wrap b0"); rd(8'h00, "R9 wrap b1"); rd(8'h00, "R9 wrap b2");
    cmd(8'h5A);
    rd(8'h0F, "R9 cnt16 lo"); rd(8'h00, "R9 cnt16 hi");

    // channel 3 left masked
    cmd(8'h93); cmd(8'h73); wr(8'h04);
    cmd(8'h23); wr(8'h00); wr(8'h01); wr(8'h00);
    cmd(8'h43); wr(8'h05); wr(8'h00);
    stb(4'h3);
    cmd(8'h53);
    rd(8'h05, "R9 masked no dec"); rd(8'h00, "R9 masked hi");

    // channel 7 armed with start clear, plus I/O port
    cmd(8'h97); cmd(8'h77); wr(8'h00); cmd(8'hA7);
    stb(4'h7);
    chk(tc, 16'h0000, "R9 start clear no tc");
    cmd(8'h57);
    rd(8'h00, "R9 start clear lo"); rd(8'h00, "R9 start clear hi");
    cmd(8'h07); wr(8'h34); wr(8'h12); wr(8'h99);
    xfer_ch = 4'h7; #1;
    chk(eng_ioport, 16'h1234, "R4 ioport");
    xfer_ch = 4'hA; #1;
    chk(eng_mode, 8'h44, "R5 mode");
    chk(armed, 16'h04A0, "R6 armed set");

    // R8 undefined command
    cmd(8'h65); wr(8'hAA);
    rd(8'h00, "R8 undefined reads zero");
    cmd(8'h35);
    rd(8'h59, "R8 addr intact b0"); rd(8'h34, "R8 addr intact b1"); rd(8'h12, "R8 addr intact b2");

    // R7 extra write ignored
    cmd(8'h25); wr(8'h11); wr(8'h22); wr(8'h33); wr(8'hEE);
    cmd(8'h35);
    rd(8'h11, "R7 extra b0"); rd(8'h22, "R7 extra b1"); rd(8'h33, "R7 extra b2");

    cmd(8'h95);
    chk(armed, 16'h0480, "R6 mask ch5");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule